// File: doc/BRIEF.md
# Accumulator Micro-Operation Executor

This block carries out the accumulator-and-link group of a small accumulator machine's instruction set. The sequencer gives it one execute strobe per instruction, together with the low twelve bits of the instruction word, the current accumulator and the one-bit link. Each of those twelve bits names one micro-operation: a clear, a complement, a rotate through the link, an increment, one of four skip tests, or a halt.

One clock edge after the strobe, the block presents the next accumulator and link values, a skip pulse, a halt pulse, and a pulse that returns the sequence counter to zero. The skip pulse tells the program-counter logic to add one extra increment. The halt pulse clears the run flag. The strobe is normally sent with only one instruction bit set. If several bits are set, the block still behaves in a fixed, defined way: the accumulator and link changes chain in a set order, and the skip tests are ORed.

Top module: `regref_exec_unit`

## Requirements
- R1: Instruction bit 11 sets the next accumulator to zero.
- R2: Instruction bit 10 sets the next link to 0. Instruction bit 8 sets the next link to the inverse of the link.
- R3: Instruction bit 9 sets the next accumulator to the bitwise inverse of the accumulator.
- R4: Instruction bit 7 rotates right through the link: the accumulator shifts right by one, its bit 15 receives the old link, and the link receives the old accumulator bit 0. Instruction bit 6 rotates left: the accumulator shifts left by one, its bit 0 receives the old link, and the link receives the old accumulator bit 15.
- R5: Instruction bit 5 adds one to the accumulator, so 0xFFFF becomes 0x0000. The link is left unchanged.
- R6: The skip output pulses when any selected test holds on the incoming values. The tests are: bit 4 with accumulator bit 15 equal to 0, bit 3 with accumulator bit 15 equal to 1, bit 2 with the accumulator all zeros, and bit 1 with the link equal to 0.
- R7: Instruction bit 0 raises the halt output.
- R8: Every strobe raises the sequence-clear output. When none of bits 11 to 5 is set, the next accumulator and link equal the incoming ones.
- R9: When several of bits 11 to 5 are set, their effects are applied one after another in the order bit 11, 10, 9, 8, 7, 6, 5. Each step works on the result of the step before it.
- R10: In a cycle without the strobe, every output of the block is zero the following cycle.
- R11: All outputs are registered. They appear one clock after the strobe and last exactly one cycle per strobe. A synchronous active-high reset sets them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| ir_i | input | 12 | Low instruction bits, one bit per micro-operation |
| acc_i | input | 16 | Current accumulator |
| link_i | input | 1 | Current link bit |
| acc_nxt_o | output | 16 | Next accumulator value |
| link_nxt_o | output | 1 | Next link value |
| skip_o | output | 1 | Extra program-counter increment pulse |
| halt_o | output | 1 | Pulse that clears the run flag |
| sc_clr_o | output | 1 | Sequence-counter clear pulse |

## Verification
The vector table drives both rotate directions with the link set and with it clear, and checks that each direction moves the correct end bit into the link. A design with swapped ends, or one that discards the link, fails these vectors. Increment is checked at 0xFFFF, where a design that lets the carry reach the link fails. Multi-bit words are chosen so that each ordering mistake gives a different result: link clear-then-invert, and rotate-then-increment. The skip tests are checked both true and false, combined with increment so that a design testing the updated accumulator instead of the incoming one is caught. The directed tests cover idle cycles with a fully set instruction word, back-to-back strobes, and a reset that lands on a strobe.

// File: rtl/regref_pkg.sv
package regref_pkg;
  // Width of the micro-operation field taken from the instruction word
  localparam int unsigned IR_W = 12;

  // Bit positions; their order also sets the order of the chained updates
  localparam int unsigned B_CLR_AC = 11;
  localparam int unsigned B_CLR_LK = 10;
  localparam int unsigned B_INV_AC = 9;
  localparam int unsigned B_INV_LK = 8;
  localparam int unsigned B_ROT_R  = 7;
  localparam int unsigned B_ROT_L  = 6;
  localparam int unsigned B_INC_AC = 5;
  localparam int unsigned B_SK_POS = 4;
  localparam int unsigned B_SK_NEG = 3;
  localparam int unsigned B_SK_ZAC = 2;
  localparam int unsigned B_SK_ZLK = 1;
  localparam int unsigned B_HALT   = 0;

  // Derived group widths
  localparam int unsigned OPS_W  = B_CLR_AC - B_INC_AC + 1;
  localparam int unsigned TEST_W = B_SK_POS - B_SK_ZLK + 1;
endpackage

// File: rtl/regref_acc_path.sv
module regref_acc_path
  import regref_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OPS_W-1:0]  op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o
);
  localparam int unsigned O_CLR_AC = B_CLR_AC - B_INC_AC;
  localparam int unsigned O_CLR_LK = B_CLR_LK - B_INC_AC;
  localparam int unsigned O_INV_AC = B_INV_AC - B_INC_AC;
  localparam int unsigned O_INV_LK = B_INV_LK - B_INC_AC;
  localparam int unsigned O_ROT_R  = B_ROT_R  - B_INC_AC;
  localparam int unsigned O_ROT_L  = B_ROT_L  - B_INC_AC;
  localparam int unsigned O_INC_AC = 0;

  logic [DATA_W-1:0] a;
  logic              l;
  logic              t;

  // Each step sees the result of the previous one
  always_comb begin
    a = acc_i;
    l = link_i;
    t = 1'b0;
    if (op_i[O_CLR_AC]) a = '0;
    if (op_i[O_CLR_LK]) l = 1'b0;
    if (op_i[O_INV_AC]) a = ~a;
    if (op_i[O_INV_LK]) l = ~l;
    if (op_i[O_ROT_R]) begin
      t = a[0];
      a = {l, a[DATA_W-1:1]};
      l = t;
    end
    if (op_i[O_ROT_L]) begin
      t = a[DATA_W-1];
      a = {a[DATA_W-2:0], l};
      l = t;
    end
    if (op_i[O_INC_AC]) a = a + {{(DATA_W-1){1'b0}}, 1'b1};
  end

  assign acc_o  = a;
  assign link_o = l;
endmodule

// File: rtl/regref_skip_eval.sv
module regref_skip_eval
  import regref_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [TEST_W-1:0] sel_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic              skip_o
);
  logic [TEST_W-1:0] cond;
  logic [TEST_W-1:0] hit;

  assign cond[B_SK_ZLK - B_SK_ZLK] = ~link_i;
  assign cond[B_SK_ZAC - B_SK_ZLK] = (acc_i == '0);
  assign cond[B_SK_NEG - B_SK_ZLK] = acc_i[DATA_W-1];
  assign cond[B_SK_POS - B_SK_ZLK] = ~acc_i[DATA_W-1];

  for (genvar g = 0; g < TEST_W; g++) begin : g_test
    assign hit[g] = sel_i[g] & cond[g];
  end

  assign skip_o = |hit;
endmodule

// File: rtl/regref_out_reg.sv
module regref_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [DATA_W-1:0] acc_n_i,
  input  logic              link_n_i,
  input  logic              skip_n_i,
  input  logic              halt_n_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              sc_clr_o
);
  always_ff @(posedge clk) begin
    if (rst || !exec_i) begin
      acc_o    <= '0;
      link_o   <= 1'b0;
      skip_o   <= 1'b0;
      halt_o   <= 1'b0;
      sc_clr_o <= 1'b0;
    end else begin
      acc_o    <= acc_n_i;
      link_o   <= link_n_i;
      skip_o   <= skip_n_i;
      halt_o   <= halt_n_i;
      sc_clr_o <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(exec_i) |-> (acc_o == '0 && !link_o && !skip_o && !halt_o && !sc_clr_o)); // R10

  AST_SC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(exec_i) && !$past(rst)) |-> sc_clr_o); // R8

  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
    sc_clr_o |-> ($past(exec_i) && !$past(rst))); // R11
endmodule

// File: rtl/regref_exec_unit.sv
module regref_exec_unit
  import regref_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] acc_nxt_o,
  output logic              link_nxt_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              sc_clr_o
);
  logic [DATA_W-1:0] acc_n;
  logic              link_n;
  logic              skip_n;

  regref_acc_path #(.DATA_W(DATA_W)) acc_path_i (
    .op_i   (ir_i[B_CLR_AC:B_INC_AC]),
    .acc_i  (acc_i),
    .link_i (link_i),
    .acc_o  (acc_n),
    .link_o (link_n)
  );

  regref_skip_eval #(.DATA_W(DATA_W)) skip_eval_i (
    .sel_i  (ir_i[B_SK_POS:B_SK_ZLK]),
    .acc_i  (acc_i),
    .link_i (link_i),
    .skip_o (skip_n)
  );

  regref_out_reg #(.DATA_W(DATA_W)) out_reg_i (
    .clk      (clk),
    .rst      (rst),
    .exec_i   (exec_i),
    .acc_n_i  (acc_n),
    .link_n_i (link_n),
    .skip_n_i (skip_n),
    .halt_n_i (ir_i[B_HALT]),
    .acc_o    (acc_nxt_o),
    .link_o   (link_nxt_o),
    .skip_o   (skip_o),
    .halt_o   (halt_o),
    .sc_clr_o (sc_clr_o)
  );

  AST_CLR_AC: assert property (@(posedge clk) disable iff (rst)
    (sc_clr_o && $past(ir_i[B_CLR_AC]) && ($past(ir_i[B_INV_AC:B_INC_AC]) == '0))
      |-> (acc_nxt_o == '0)); // R1

  AST_SKIP_SRC: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> ($past(exec_i) && ($past(ir_i[B_SK_POS:B_SK_ZLK]) != '0))); // R6

  AST_HALT_SRC: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> ($past(exec_i) && $past(ir_i[B_HALT]))); // R7

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (sc_clr_o && ($past(ir_i[B_CLR_AC:B_INC_AC]) == '0))
      |-> (acc_nxt_o == $past(acc_i) && link_nxt_o == $past(link_i))); // R8
endmodule

// File: tb/regref_exec_unit_tb.sv
module regref_exec_unit_tb_top;
  localparam int unsigned DW = 16;
  localparam int unsigned NV = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exec_i = 1'b0;
  logic [11:0]   ir_i = '0;
  logic [DW-1:0] acc_i = '0;
  logic          link_i = 1'b0;
  logic [DW-1:0] acc_nxt_o;
  logic          link_nxt_o, skip_o, halt_o, sc_clr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regref_exec_unit #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .exec_i(exec_i), .ir_i(ir_i), .acc_i(acc_i),
    .link_i(link_i), .acc_nxt_o(acc_nxt_o), .link_nxt_o(link_nxt_o),
    .skip_o(skip_o), .halt_o(halt_o), .sc_clr_o(sc_clr_o)
  );

  // {req, ir, acc, link, exp_acc, exp_link, exp_skip, exp_halt}
  localparam logic [51:0] VEC [NV] = '{
    {4'd1, 12'h800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0}, // R1
    {4'd2, 12'h400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0}, // R2
    {4'd2, 12'h100, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R2
    {4'd3, 12'h200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0}, // R3
    {4'd4, 12'h080, 16'h8001, 1'b0, 16'h4000, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 12'h080, 16'h0002, 1'b1, 16'h8001, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 12'h040, 16'h8001, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 12'h040, 16'h4000, 1'b1, 16'h8001, 1'b0, 1'b0, 1'b0}, // R4
    {4'd5, 12'h020, 16'h00FF, 1'b1, 16'h0100, 1'b1, 1'b0, 1'b0}, // R5
    {4'd5, 12'h020, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R5
    {4'd6, 12'h010, 16'h7FFF, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b0}, // R6
    {4'd6, 12'h010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0}, // R6
    {4'd6, 12'h008, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b0}, // R6
    {4'd6, 12'h008, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0}, // R6
    {4'd6, 12'h004, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0}, // R6
    {4'd6, 12'h004, 16'h0010, 1'b1, 16'h0010, 1'b1, 1'b0, 1'b0}, // R6
    {4'd6, 12'h002, 16'h5555, 1'b0, 16'h5555, 1'b0, 1'b1, 1'b0}, // R6
    {4'd6, 12'h002, 16'h5555, 1'b1, 16'h5555, 1'b1, 1'b0, 1'b0}, // R6
    {4'd7, 12'h001, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0, 1'b1}, // R7
    {4'd8, 12'h000, 16'h3C3C, 1'b0, 16'h3C3C, 1'b0, 1'b0, 1'b0}, // R8
    {4'd9, 12'hA00, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0}, // R9
    {4'd9, 12'h220, 16'h0005, 1'b1, 16'hFFFB, 1'b1, 1'b0, 1'b0}, // R9
    {4'd9, 12'h500, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R9
    {4'd9, 12'h0A0, 16'h0003, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0}, // R9
    {4'd6, 12'h024, 16'h0000, 1'b1, 16'h0001, 1'b1, 1'b1, 1'b0}, // R6 incoming AC
    {4'd6, 12'h00C, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R6 ORed
    {4'd6, 12'h016, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0}, // R6 none hold
    {4'd7, 12'h803, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1}  // R7 with R1
  };

  task automatic check(input string req, input logic [DW-1:0] ea, input logic el,
                       input logic es, input logic eh, input logic ec);
    n_chk++;
    if (acc_nxt_o !== ea || link_nxt_o !== el || skip_o !== es ||
        halt_o !== eh || sc_clr_o !== ec) begin
      n_bad++;
      $display("FAIL %s: got acc=%h link=%b skip=%b halt=%b sc=%b, want acc=%h link=%b skip=%b halt=%b sc=%b",
               req, acc_nxt_o, link_nxt_o, skip_o, halt_o, sc_clr_o, ea, el, es, eh, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", '0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // Table walk: strobe on every cycle
    for (int i = 0; i < NV; i++) begin
      exec_i = 1'b1;
      {ir_i, acc_i, link_i} = VEC[i][47:19];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][51:48], i), VEC[i][18:3], VEC[i][2],
            VEC[i][1], VEC[i][0], 1'b1);
    end

    // R10: idle with every bit set
    exec_i = 1'b0; ir_i = 12'hFFF; acc_i = 16'h1234; link_i = 1'b0;
    @(negedge clk);
    check("R10 idle", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: back-to-back skips give one pulse each, then drop
    exec_i = 1'b1; ir_i = 12'h004; acc_i = 16'h0000; link_i = 1'b1;
    @(negedge clk);
    check("R11 b2b first", 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R11 b2b second", 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    exec_i = 1'b0;
    @(negedge clk);
    check("R11 pulse ends", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: reset wins over a strobe
    rst = 1'b1; exec_i = 1'b1; ir_i = 12'h001; acc_i = 16'hBEEF;
    @(negedge clk);
    check("R11 reset over strobe", '0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0; exec_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule